// File: doc/BRIEF.md
# Serial Configuration Chain Shifter

The block is a register-driven controller for long internal serial configuration chains, one chain per lane group. Software programs a control register with a clock divider, the group whose serial return is listened to, and a mask of bypassed groups. It then loads a 32-bit shift register and writes a command register that holds a bit count, a one-hot group select and three command bits. The controller moves bits out of the low end of the shift register into the selected chains on a divided chain clock. It takes the returning bits in at the high end. It can also issue a single update strobe (the chain contents are copied into all lanes of the group) or a capture strobe (the chain is loaded from all lanes).

Each command bit reads as one for as long as its operation runs and drops by itself at the end, so software polls the command register until it reads zero. A chain longer than 32 bits, such as four lanes of 268 bits, is filled by issuing repeated shift commands. After an N-bit shift the returned bits occupy the top N bits of the shift register. Software obtains them by shifting the register right by 32-N.

Top module: `chain_shift_ctrl`

## Requirements
- R1: After reset the control register (address 0), the shift register (address 1) and the command register (address 2) all read zero, and every chain clock, update strobe and capture strobe is low.
- R2: Writing address 2 with bit 8 set starts a shift whose length is the value in bits 4:0 plus one, from 1 to 32 bits. Each selected chain receives exactly that many chain-clock pulses.
- R3: The chain clock period is P = 2^(D+2) system clocks, where D is control bits 2:0. Within each bit period the chain clock is low for the first P/2 cycles and high for the last P/2 cycles.
- R4: Shift-register bit 0 is the bit sent out on every chain serial output, and it leaves first. The bit returned by the chain is taken in at bit 31. After an N-bit shift, returned bit i (0 is the first) sits at position 32-N+i, and the loaded data bits N..31 sit at positions 0..31-N.
- R5: A command bit reads one on address 2 for exactly N*P system cycles after the write for a shift, and for exactly P cycles for update or capture. After that it reads zero.
- R6: Writing address 2 with bit 9 set raises the update strobe of each selected group for exactly P cycles. Bit 10 does the same for the capture strobe. The chain clock stays low during both, and the strobe falls on the same edge that clears the command bit.
- R7: While a command is running, every register write is ignored at all three addresses. This includes a write that sets another command bit.
- R8: Control bits 19:16 hold a per-group bypass mask. A bypassed group receives no chain clock and no strobes. If the listened-to group is bypassed, the returned bit equals the bit being sent, so the shift register rotates right.
- R9: If more than one command bit is set in the same write, only one operation runs: shift takes priority over update, and update over capture.
- R10: Command bits 19:16 are the one-hot group select, and only selected groups receive clocks or strobes. Control bits 9:8 choose the group whose serial input is returned into the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Register write enable, one cycle per write |
| csr_addr | input | 2 | Register address: 0 control, 1 shift data, 2 command |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for csr_addr, combinational |
| chain_clk | output | GROUPS | Divided chain clock, one per group |
| chain_sdo | output | GROUPS | Serial data into each chain |
| chain_sdi | input | GROUPS | Serial data returned from each chain |
| chain_upd | output | GROUPS | Update strobe, one per group |
| chain_cap | output | GROUPS | Capture strobe, one per group |

## Verification
The hardest situation to reach from the ports is a write that arrives while a command is still running, including one that sets a second command bit on the exact edge where busy clears. The stimulus starts a long, slowly divided shift and then issues shift-data, command and control writes in the middle of it. The result is then checked against the undisturbed expected shift, the unchanged count field and untouched lanes. The second hard case is the bypass loop, where the returned bit is the transmitted bit itself. It is reached by pointing the listened-to group at a bypassed group, which makes the register rotate while the chain model keeps its contents.

// File: rtl/chain_shift_pkg.sv
// Package: shared types and register field positions for the chain shifter.
// Assumes a 32-bit register interface and at most 8 groups, so that the
// select and bypass fields fit in bits 23:16.
package chain_shift_pkg;
    localparam int SHIFT_W       = 32;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_DATA     = 1;
    localparam int ADDR_CMD      = 2;
    localparam int CTL_MUX_LSB   = 8;
    localparam int CTL_BYP_LSB   = 16;
    localparam int CMD_SHIFT_BIT = 8;
    localparam int CMD_UPD_BIT   = 9;
    localparam int CMD_CAP_BIT   = 10;
    localparam int CMD_SEL_LSB   = 16;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_UPDATE  = 2'd2,
        OP_CAPTURE = 2'd3
    } op_e;
endpackage

// File: rtl/chain_csr_regs.sv
// Module: register file of the chain shifter. It holds the control fields
// (divider, return mux, bypass mask) and the command fields (count, select).
// It turns a command write into one start request, applying the priority
// shift > update > capture. Every write is ignored while busy is high.
// Assumes that the shift register itself lives in the engine.
module chain_csr_regs
    import chain_shift_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int DIV_W  = 3,
    parameter int SEL_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [1:0]         csr_addr,
    input  logic [31:0]        csr_wdata,
    input  logic               busy,
    input  op_e                op,
    input  logic [SHIFT_W-1:0] shreg,
    output logic [DIV_W-1:0]   div,
    output logic [SEL_W-1:0]   mux,
    output logic [GROUPS-1:0]  byp,
    output logic [GROUPS-1:0]  sel,
    output logic [CNT_W-1:0]   cnt,
    output op_e                start_op,
    output logic               load_sh,
    output logic [31:0]        csr_rdata
);
    logic wr_ok;
    assign wr_ok = csr_we && !busy;

    // Field storage: accepted writes update the control and command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div <= '0;
            mux <= '0;
            byp <= '0;
            sel <= '0;
            cnt <= '0;
        end else if (wr_ok) begin
            if (csr_addr == 2'(ADDR_CTRL)) begin
                div <= csr_wdata[DIV_W-1:0];
                mux <= csr_wdata[CTL_MUX_LSB +: SEL_W];
                byp <= csr_wdata[CTL_BYP_LSB +: GROUPS];
            end else if (csr_addr == 2'(ADDR_CMD)) begin
                sel <= csr_wdata[CMD_SEL_LSB +: GROUPS];
                cnt <= csr_wdata[CNT_W-1:0];
            end
        end
    end

    // Command decode with fixed priority among the three command bits.
    always_comb begin
        start_op = OP_IDLE;
        if (wr_ok && csr_addr == 2'(ADDR_CMD)) begin
            if (csr_wdata[CMD_SHIFT_BIT])    start_op = OP_SHIFT;
            else if (csr_wdata[CMD_UPD_BIT]) start_op = OP_UPDATE;
            else if (csr_wdata[CMD_CAP_BIT]) start_op = OP_CAPTURE;
        end
    end

    assign load_sh = wr_ok && (csr_addr == 2'(ADDR_DATA));

    // Read mux: the command bits read back as the running operation.
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            2'(ADDR_CTRL): begin
                csr_rdata[DIV_W-1:0]            = div;
                csr_rdata[CTL_MUX_LSB +: SEL_W] = mux;
                csr_rdata[CTL_BYP_LSB +: GROUPS] = byp;
            end
            2'(ADDR_DATA): csr_rdata = shreg;
            2'(ADDR_CMD): begin
                csr_rdata[CNT_W-1:0]             = cnt;
                csr_rdata[CMD_SHIFT_BIT]         = (op == OP_SHIFT);
                csr_rdata[CMD_UPD_BIT]           = (op == OP_UPDATE);
                csr_rdata[CMD_CAP_BIT]           = (op == OP_CAPTURE);
                csr_rdata[CMD_SEL_LSB +: GROUPS] = sel;
            end
            default: csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chain_phase_gen.sv
// Module: phase counter for the divided chain clock. While run is high it
// counts 0..P-1 with P = 2^(div+2) and wraps. It flags the last cycle of a
// period, the cycle before the high half, and the high half itself.
// Assumes div is held constant while run is high.
module chain_phase_gen #(
    parameter int DIV_W = 3,
    parameter int PH_W  = (1 << DIV_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             ph_mid,
    output logic             ph_last,
    output logic             ph_high
);
    logic [PH_W-1:0] ph_cnt;
    logic [PH_W-1:0] ph_mask;
    logic [PH_W-1:0] ph_half;

    // Period mask: P-1 for the programmed divider, wrapping to all ones at the top.
    always_comb begin
        ph_mask = (PH_W'(1) << (int'(div) + 2)) - PH_W'(1);
        ph_half = ph_mask >> 1;
    end

    // Phase counter: free-running inside a command, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)      ph_cnt <= '0;
        else if (ph_cnt == ph_mask) ph_cnt <= '0;
        else                     ph_cnt <= ph_cnt + PH_W'(1);
    end

    assign ph_mid  = run && (ph_cnt == ph_half);
    assign ph_last = run && (ph_cnt == ph_mask);
    assign ph_high = run && (ph_cnt > ph_half);
endmodule

// File: rtl/chain_shift_engine.sv
// Module: operation sequencer and 32-bit shift register. A shift moves one
// bit per chain-clock period. The returned bit is sampled just before the
// chain clock rises and enters at the MSB when the period ends. Update and
// capture last one period. Assumes start_op and load_sh only pulse while idle.
module chain_shift_engine
    import chain_shift_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  op_e                start_op,
    input  logic               load_sh,
    input  logic [SHIFT_W-1:0] load_data,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               ph_mid,
    input  logic               ph_last,
    input  logic               ret_in,
    output op_e                op,
    output logic [SHIFT_W-1:0] shreg,
    output logic               busy
);
    logic [CNT_W-1:0] bit_idx;
    logic             ret_q;

    // Sequencer: start, per-bit shifting and completion of each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op      <= OP_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            ret_q   <= 1'b0;
        end else begin
            case (op)
                OP_IDLE: begin
                    if (load_sh) shreg <= load_data;
                    if (start_op != OP_IDLE) begin
                        op      <= start_op;
                        bit_idx <= '0;
                    end
                end
                OP_SHIFT: begin
                    if (ph_mid) ret_q <= ret_in;
                    if (ph_last) begin
                        shreg <= {ret_q, shreg[SHIFT_W-1:1]};
                        if (bit_idx == cnt) op <= OP_IDLE;
                        else                bit_idx <= bit_idx + CNT_W'(1);
                    end
                end
                default: begin
                    if (ph_last) op <= OP_IDLE;
                end
            endcase
        end
    end

    assign busy = (op != OP_IDLE);
endmodule

// File: rtl/chain_shift_ctrl.sv
// Module: top of the serial chain shifter. It joins the register file, the
// phase counter and the engine, and fans the chain clock and strobes out to
// the selected, non-bypassed groups. The serial return is taken from the
// group named by the mux field, or looped from the output if that group is
// bypassed. Assumes GROUPS <= 8.
module chain_shift_ctrl
    import chain_shift_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [1:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic [GROUPS-1:0] chain_clk,
    output logic [GROUPS-1:0] chain_sdo,
    input  logic [GROUPS-1:0] chain_sdi,
    output logic [GROUPS-1:0] chain_upd,
    output logic [GROUPS-1:0] chain_cap
);
    localparam int SEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int CNT_W = $clog2(SHIFT_W);

    logic [DIV_W-1:0]   div;
    logic [SEL_W-1:0]   mux;
    logic [GROUPS-1:0]  byp;
    logic [GROUPS-1:0]  cmd_sel;
    logic [CNT_W-1:0]   cmd_cnt;
    op_e                start_op;
    op_e                op;
    logic               load_sh;
    logic [SHIFT_W-1:0] shreg;
    logic               busy;
    logic               ph_mid;
    logic               ph_last;
    logic               ph_high;
    logic               ret_in;

    chain_csr_regs #(.GROUPS(GROUPS), .DIV_W(DIV_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .busy(busy), .op(op), .shreg(shreg),
        .div(div), .mux(mux), .byp(byp), .sel(cmd_sel), .cnt(cmd_cnt),
        .start_op(start_op), .load_sh(load_sh), .csr_rdata(csr_rdata)
    );

    chain_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(div),
        .ph_mid(ph_mid), .ph_last(ph_last), .ph_high(ph_high)
    );

    chain_shift_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start_op(start_op), .load_sh(load_sh),
        .load_data(csr_wdata), .cnt(cmd_cnt), .ph_mid(ph_mid), .ph_last(ph_last),
        .ret_in(ret_in), .op(op), .shreg(shreg), .busy(busy)
    );

    // Return mux: listened-to group's serial input, or a loop in bypass.
    always_comb begin
        ret_in = 1'b0;
        for (int g = 0; g < GROUPS; g++) begin
            if (mux == SEL_W'(g)) ret_in = byp[g] ? shreg[0] : chain_sdi[g];
        end
    end

    // Per-group fan-out of clock, data and strobes.
    for (genvar g = 0; g < GROUPS; g++) begin : g_fan
        logic live;
        assign live         = cmd_sel[g] && !byp[g];
        assign chain_clk[g] = live && (op == OP_SHIFT) && ph_high;
        assign chain_upd[g] = live && (op == OP_UPDATE);
        assign chain_cap[g] = live && (op == OP_CAPTURE);
        assign chain_sdo[g] = shreg[0];
    end
endmodule

// File: rtl/chain_shift_chk.sv
// Module: property checker for the chain shifter, bound to the top.
// Assumes the top's internal names busy, op, cmd_sel and cmd_cnt.
module chain_shift_chk
    import chain_shift_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_we,
    input logic [1:0]        csr_addr,
    input logic [31:0]       csr_wdata,
    input logic [GROUPS-1:0] chain_clk,
    input logic [GROUPS-1:0] chain_upd,
    input logic [GROUPS-1:0] chain_cap,
    input logic              busy,
    input op_e               op,
    input logic [GROUPS-1:0] cmd_sel,
    input logic [CNT_W-1:0]  cmd_cnt
);
    // R3
    clk_only_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chain_clk) |-> (op == OP_SHIFT));

    // R7
    cmd_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && csr_we) |=> ($stable(cmd_sel) && $stable(cmd_cnt)));

    // R9
    shift_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && csr_we && csr_addr == 2'(ADDR_CMD) && csr_wdata[CMD_SHIFT_BIT])
        |=> (op == OP_SHIFT));

    // R5
    busy_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && csr_we && csr_addr == 2'(ADDR_CMD) && (|csr_wdata[CMD_CAP_BIT:CMD_SHIFT_BIT]))
        |=> busy);

    // R6
    upd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|chain_upd) |-> !busy);

    // R6
    outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|chain_clk, |chain_upd, |chain_cap}));
endmodule

bind chain_shift_ctrl chain_shift_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .chain_clk(chain_clk), .chain_upd(chain_upd),
    .chain_cap(chain_cap), .busy(busy), .op(op), .cmd_sel(cmd_sel),
    .cmd_cnt(cmd_cnt)
);

// File: tb/sim_chain_shift_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference of the controller timing, compared on every
// clock, plus chain and lane models driven by the design's outputs.
module sim_chain_shift_ctrl;
    localparam int G = 4;
    localparam int L = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = 2'd0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic [G-1:0]  chain_clk, chain_sdo, chain_sdi, chain_upd, chain_cap;
    logic [L-1:0]  ch_view [G];
    logic [L-1:0]  lane_view [G];
    logic [L-1:0]  exp_ch [G];
    logic [L-1:0]  exp_lane [G];

    int n_chk = 0;
    int n_err = 0;
    int cur_div = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chain_shift_ctrl #(.GROUPS(G), .DIV_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .chain_clk(chain_clk),
        .chain_sdo(chain_sdo), .chain_sdi(chain_sdi), .chain_upd(chain_upd),
        .chain_cap(chain_cap)
    );

    function automatic logic [L-1:0] chain_init(int g);
        return {8'(g * 37 + 5), 32'h9E3779B9 * 32'(g + 1)};
    endfunction
    function automatic logic [L-1:0] lane_init(int g);
        return {8'(g * 11 + 200), 32'h85EBCA6B ^ 32'(g * 32'h01010101)};
    endfunction

    // Chain and lane models of each group.
    for (genvar g = 0; g < G; g++) begin : gch
        logic [L-1:0] ch = chain_init(g);
        logic [L-1:0] lane = lane_init(g);
        always @(posedge chain_clk[g] or posedge chain_cap[g])
            if (chain_cap[g]) ch <= lane;
            else              ch <= {chain_sdo[g], ch[L-1:1]};
        always @(posedge chain_upd[g]) lane <= ch;
        assign chain_sdi[g]  = ch[0];
        assign ch_view[g]    = ch;
        assign lane_view[g]  = lane;
    end

    task automatic chk(string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    // Reference timing model: which operation runs and how far it is.
    int       m_t, m_len, m_div, m_op;
    bit       m_busy;
    bit [G-1:0] m_sel, m_byp;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_len = 0; m_div = 0; m_op = 0; m_sel = '0; m_byp = '0;
        end else if (m_busy) begin
            if (m_t == m_len - 1) m_busy = 0;
            else m_t++;
        end else if (csr_we) begin
            if (csr_addr == 2'd0) begin
                m_div = int'(csr_wdata[2:0]);
                m_byp = csr_wdata[16 +: G];
            end else if (csr_addr == 2'd2) begin
                m_sel = csr_wdata[16 +: G];
                m_op  = csr_wdata[8] ? 1 : csr_wdata[9] ? 2 : csr_wdata[10] ? 3 : 0;
                if (m_op != 0) begin
                    m_busy = 1; m_t = 0;
                    m_len = (m_op == 1 ? int'(csr_wdata[4:0]) + 1 : 1) * (1 << (m_div + 2));
                end
            end
        end
    end

    // Per-clock comparison of chain clock and strobes (R3, R6, R8, R10).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [G-1:0] e_clk, e_upd, e_cap;
            int per;
            per = 1 << (m_div + 2);
            for (int g = 0; g < G; g++) begin
                bit live;
                live = m_busy && m_sel[g] && !m_byp[g];
                e_clk[g] = live && m_op == 1 && ((m_t % per) >= per / 2);
                e_upd[g] = live && m_op == 2;
                e_cap[g] = live && m_op == 3;
            end
            chk("R3 chain clock per cycle", 64'(chain_clk), 64'(e_clk));
            chk("R6 update strobe per cycle", 64'(chain_upd), 64'(e_upd));
            chk("R6 capture strobe per cycle", 64'(chain_cap), 64'(e_cap));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic poll(output int cyc);
        cyc = 0;
        csr_addr = 2'd2;
        #1;
        while (csr_rdata[10:8] != 3'b000 && cyc < 100000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic set_ctrl(int dv, int mx, logic [G-1:0] bp);
        wr(2'd0, 32'(dv) | (32'(mx) << 8) | (32'(bp) << 16));
        cur_div = dv;
    endtask

    function automatic logic [31:0] cmd_word(int g, int n, logic [2:0] bits);
        return (32'(1) << (16 + g)) | (32'(bits) << 8) | 32'(n - 1);
    endfunction

    // Shift n bits into group g; the expected result follows R2 and R4.
    task automatic do_shift(int g, int n, logic [31:0] data, bit loopb, string tag);
        int cyc;
        logic [31:0] res, r;
        logic b;
        wr(2'd1, data);
        wr(2'd2, cmd_word(g, n, 3'b001));
        poll(cyc);
        chk({tag, " R5 shift busy cycles"}, 64'(cyc), 64'(n * (1 << (cur_div + 2))));
        rd(2'd1, res);
        r = data;
        for (int i = 0; i < n; i++) begin
            b = loopb ? r[0] : exp_ch[g][0];
            if (!loopb) exp_ch[g] = {r[0], exp_ch[g][L-1:1]};
            r = {b, r[31:1]};
        end
        chk({tag, " R4 shift register result"}, 64'(res), 64'(r));
        chk({tag, " R2 chain contents"}, 64'(ch_view[g]), 64'(exp_ch[g]));
    endtask

    task automatic do_strobe(int g, logic [2:0] bits, string tag);
        int cyc;
        wr(2'd2, cmd_word(g, 1, bits));
        poll(cyc);
        chk({tag, " R5 strobe busy cycles"}, 64'(cyc), 64'(1 << (cur_div + 2)));
    endtask

    initial begin
        logic [31:0] v;
        int cyc;
        for (int g = 0; g < G; g++) begin
            exp_ch[g] = chain_init(g);
            exp_lane[g] = lane_init(g);
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); chk("R1 control reset", 64'(v), 0);
        rd(2'd1, v); chk("R1 shift reset", 64'(v), 0);
        rd(2'd2, v); chk("R1 command reset", 64'(v), 0);
        chk("R1 outputs low", 64'({chain_clk, chain_upd, chain_cap}), 0);

        // R2 R3 R4 full and partial shifts at several dividers (R10 mux)
        set_ctrl(0, 0, '0);
        do_shift(0, 32, 32'hC3A50F1E, 0, "A");
        do_shift(0, 8, 32'h0000005A, 0, "B");
        set_ctrl(1, 1, '0);
        do_shift(1, 1, 32'h00000001, 0, "C");
        do_shift(1, 17, 32'h1234ABCD, 0, "D");

        // R6 update into group 2
        set_ctrl(0, 2, '0);
        do_shift(2, 32, 32'hF00DCAFE, 0, "E");
        do_strobe(2, 3'b010, "E");
        exp_lane[2] = exp_ch[2];
        chk("R6 update copies chain to lanes", 64'(lane_view[2]), 64'(exp_lane[2]));

        // R6 capture into group 0, then read back by shifting
        set_ctrl(2, 0, '0);
        do_strobe(0, 3'b100, "F");
        exp_ch[0] = exp_lane[0];
        chk("R6 capture loads chain from lanes", 64'(ch_view[0]), 64'(exp_ch[0]));
        do_shift(0, 32, 32'h0, 0, "F");

        // R7 writes ignored while busy
        wr(2'd1, 32'h8765_4321);
        wr(2'd2, cmd_word(0, 16, 3'b001));
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, cmd_word(1, 4, 3'b010));
        wr(2'd0, 32'h0003_0105);
        poll(cyc);
        begin
            logic [31:0] r;
            logic b;
            r = 32'h8765_4321;
            for (int i = 0; i < 16; i++) begin
                b = exp_ch[0][0];
                exp_ch[0] = {r[0], exp_ch[0][L-1:1]};
                r = {b, r[31:1]};
            end
            rd(2'd1, v); chk("R7 shift data kept during busy", 64'(v), 64'(r));
        end
        rd(2'd2, v); chk("R7 command fields kept", 64'(v), 64'(cmd_word(0, 16, 3'b000)));
        rd(2'd0, v); chk("R7 control kept", 64'(v), 64'(32'h2));
        chk("R7 lanes of group 1 untouched", 64'(lane_view[1]), 64'(exp_lane[1]));

        // R8 bypass loop on group 3
        set_ctrl(0, 3, 4'b1000);
        do_shift(3, 12, 32'hABC0_0F5A, 1, "G");
        do_strobe(3, 3'b010, "G");
        chk("R8 bypassed lanes untouched", 64'(lane_view[3]), 64'(exp_lane[3]));

        // R9 priority: all three bits run a shift; update beats capture
        set_ctrl(0, 1, '0);
        wr(2'd1, 32'h0000_0009);
        wr(2'd2, cmd_word(1, 4, 3'b111));
        poll(cyc);
        chk("R9 shift wins busy cycles", 64'(cyc), 64'(16));
        for (int i = 0; i < 4; i++) exp_ch[1] = {1'(32'h9 >> i), exp_ch[1][L-1:1]};
        chk("R9 chain shifted", 64'(ch_view[1]), 64'(exp_ch[1]));
        chk("R9 no update with shift", 64'(lane_view[1]), 64'(exp_lane[1]));
        do_strobe(1, 3'b110, "H");
        exp_lane[1] = exp_ch[1];
        chk("R9 update beats capture", 64'(lane_view[1]), 64'(exp_lane[1]));
        chk("R9 chain not captured", 64'(ch_view[1]), 64'(exp_ch[1]));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule